// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that answers on a two-wire bus as a byte-addressed serial EEPROM. A fast system clock oversamples the open-drain SCL and SDA lines through synchronisers. The block finds START and STOP conditions and SCL edges, and pulls SDA low through a single enable output. The host addresses it with a control byte. For writes, two word-address bytes follow. Data bytes then either fill a 64-byte page staging buffer or are streamed out of the array.

Staged bytes reach the array only after a STOP, during a timed write cycle whose length is a parameter in system clock cycles. While that cycle runs, the target refuses its control byte, so a host can poll for completion by repeating START and the control byte until it is acknowledged. A write-control input blocks all writes.

The array depth is set by `ARR_AW`. The default of 11 keeps elaboration small, and 14 gives the full 16 KB part. Word-address bits above `ARR_AW` are ignored.

Top module: `ser_eeprom_tgt`

## Requirements
- R1: After reset SDA is released (`sda_pull_o` = 0) and a matching control byte is acknowledged at once.
- R2: A control byte is accepted only when bits [7:4] are 1010 and bits [3:1] equal `sel_strap`; bit 0 selects read (1) or write (0). Any other control byte gets no acknowledge, and the target stays silent until the next START.
- R3: A write control byte is followed by a high and a low word-address byte. Address bits at and above `ARR_AW` are ignored, so with `ARR_AW` = 11 address 0x0810 reads the same byte as 0x0010.
- R4: A single data byte followed by STOP writes that byte to the addressed location.
- R5: During a page write the pointer steps through the low 6 address bits only. Bytes past the end of a 64-byte page wrap to the start of the same page, and the neighbouring page is unchanged.
- R6: A random read is a write control byte, two address bytes, a repeated START, a read control byte, and then the data at that address.
- R7: A current-address read with no address bytes returns the byte at the pointer left by the previous operation.
- R8: A sequential read increments the pointer after every byte. It crosses page boundaries and wraps from the last array address to 0.
- R9: After a STOP that ends a write carrying data, the control byte is refused for `WC_CYCLES` clock cycles and acknowledged again afterwards. While this cycle runs, SDA is never pulled.
- R10: While `wr_lock` is 1, the address bytes are acknowledged and data bytes are not. The array is unchanged and no write cycle starts.
- R11: A START that arrives before the STOP discards the staged data of a write.
- R12: The target changes its SDA drive only while SCL is low.
- R13: A write control byte and address bytes followed by STOP, with no data, start no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level (wired-AND of all drivers) |
| sel_strap | input | 3 | Chip-select strap compared with control byte bits [3:1] |
| wr_lock | input | 1 | Write control: 1 blocks every write |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can meet in the same window. One is the end of a page write, where the STOP launches the timed commit. The other is a new START with a control byte that the host sends immediately after that STOP. The bench provokes this by issuing acknowledge polls right behind each data write. It requires the first poll to be refused and a later poll to be accepted, and then reads back the committed bytes through random, current-address and sequential reads. The same overlap is also provoked with `wr_lock` high and with a repeated START before the STOP. In both cases the very next poll must be acknowledged, because no commit may have started.

// File: rtl/seep_pkg.sv
package seep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } xfer_st_e;

    typedef enum logic [1:0] {
        PH_BITS,
        PH_DACK,
        PH_HACK
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync
    import seep_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_N-1:0] scl_m, sda_m;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= '1;
            sda_m <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= {scl_m[SYNC_N-2:0], scl_i};
            sda_m <= {sda_m[SYNC_N-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s = scl_m[SYNC_N-1];
    assign sda_s = sda_m[SYNC_N-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/seep_page_stage.sv
module seep_page_stage #(
    parameter int PG_AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PG_AW-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    input  logic [PG_AW-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    localparam int PG_N = 1 << PG_AW;

    logic [7:0]      buf_q [PG_N];
    logic [PG_N-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            buf_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data   = buf_q[rd_idx];
    assign rd_valid  = vld_q[rd_idx];
    assign any_valid = |vld_q;
endmodule

// File: rtl/seep_store.sv
module seep_store #(
    parameter int AW     = 11,
    parameter int PG_AW  = 6,
    parameter int WC_CYC = 400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [AW-PG_AW-1:0] page,
    output logic                busy,
    output logic                done,
    output logic [PG_AW-1:0]    st_idx,
    input  logic [7:0]          st_data,
    input  logic                st_vld,
    input  logic [AW-1:0]       rd_addr,
    output logic [7:0]          rd_q
);
    localparam int DEPTH = 1 << AW;
    localparam int PG_N  = 1 << PG_AW;
    localparam int CW    = $clog2(WC_CYC + 1);

    logic [7:0]          mem [DEPTH];
    logic [CW-1:0]       cnt_q;
    logic                busy_q;
    logic [AW-PG_AW-1:0] page_q;
    logic                mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                page_q <= page;
            end
        end else begin
            if (cnt_q == CW'(WC_CYC - 1)) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign st_idx = cnt_q[PG_AW-1:0];
    assign mem_we = busy_q && (cnt_q < CW'(PG_N)) && st_vld;
    assign busy   = busy_q;
    assign done   = busy_q && (cnt_q == CW'(WC_CYC - 1));

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{page_q, st_idx}] <= st_data;
        end
        rd_q <= mem[rd_addr];
    end
endmodule

// File: rtl/seep_xfer_fsm.sv
module seep_xfer_fsm
    import seep_pkg::*;
#(
    parameter int AW    = 11,
    parameter int PG_AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_ev_t             ev,
    input  logic [2:0]          strap,
    input  logic                lock,
    input  logic                busy,
    input  logic                any_valid,
    input  logic [7:0]          rd_q,
    output logic                pull,
    output logic                st_we,
    output logic [PG_AW-1:0]    st_idx,
    output logic [7:0]          st_data,
    output logic                go,
    output logic                clr,
    output logic [AW-PG_AW-1:0] page,
    output logic [AW-1:0]       ptr
);
    localparam int HI_W = AW - 8;

    xfer_st_e        st_q, nxt_st;
    phase_e          ph_q;
    logic [3:0]      bcnt_q;
    logic [7:0]      sh_q, tx_q;
    logic [AW-1:0]   ptr_q, nxt_ptr;
    logic [HI_W-1:0] ahi_q;
    logic            pull_q, ack_now, byte_done, rd_load, quiet;

    assign quiet     = !ev.start && !ev.stop;
    assign byte_done = (ph_q == PH_BITS) && ev.scl_fall && (bcnt_q == 4'd8) && quiet;
    assign rd_load   = (st_q == ST_RDAT) && (ph_q != PH_BITS) && ev.scl_fall && quiet;

    always_comb begin
        nxt_st  = ST_SKIP;
        ack_now = 1'b0;
        nxt_ptr = ptr_q;
        unique case (st_q)
            ST_CTRL: begin
                if (ctrl_match(sh_q, strap) && !busy) begin
                    ack_now = 1'b1;
                    nxt_st  = sh_q[0] ? ST_RDAT : ST_AHI;
                end
            end
            ST_AHI: begin
                ack_now = 1'b1;
                nxt_st  = ST_ALO;
            end
            ST_ALO: begin
                ack_now = 1'b1;
                nxt_st  = ST_WDAT;
                nxt_ptr = {ahi_q, sh_q};
            end
            ST_WDAT: begin
                if (!lock) begin
                    ack_now = 1'b1;
                    nxt_st  = ST_WDAT;
                    nxt_ptr = {ptr_q[AW-1:PG_AW], ptr_q[PG_AW-1:0] + PG_AW'(1)};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_BITS;
            bcnt_q <= '0;
            sh_q   <= '0;
            tx_q   <= '0;
            ptr_q  <= '0;
            ahi_q  <= '0;
            pull_q <= 1'b0;
        end else if (ev.start) begin
            st_q   <= ST_CTRL;
            ph_q   <= PH_BITS;
            bcnt_q <= '0;
            pull_q <= 1'b0;
        end else if (ev.stop) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_BITS;
            pull_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (ph_q == PH_BITS) begin
                        if (ev.scl_rise && bcnt_q != 4'd8) begin
                            sh_q   <= {sh_q[6:0], ev.sda};
                            bcnt_q <= bcnt_q + 4'd1;
                        end
                        if (byte_done) begin
                            ph_q   <= PH_DACK;
                            bcnt_q <= '0;
                            pull_q <= ack_now;
                            st_q   <= nxt_st;
                            ptr_q  <= nxt_ptr;
                            if (st_q == ST_AHI) begin
                                ahi_q <= sh_q[HI_W-1:0];
                            end
                        end
                    end else if (ev.scl_fall) begin
                        ph_q   <= PH_BITS;
                        pull_q <= 1'b0;
                    end
                end
                ST_RDAT: begin
                    if (rd_load) begin
                        tx_q   <= {rd_q[6:0], 1'b0};
                        pull_q <= ~rd_q[7];
                        bcnt_q <= 4'd1;
                        ptr_q  <= ptr_q + AW'(1);
                        ph_q   <= PH_BITS;
                    end else if (ph_q == PH_BITS && ev.scl_fall) begin
                        if (bcnt_q == 4'd8) begin
                            pull_q <= 1'b0;
                            ph_q   <= PH_HACK;
                        end else begin
                            pull_q <= ~tx_q[7];
                            tx_q   <= {tx_q[6:0], 1'b0};
                            bcnt_q <= bcnt_q + 4'd1;
                        end
                    end else if (ph_q == PH_HACK && ev.scl_rise && ev.sda) begin
                        st_q <= ST_SKIP;
                    end
                end
                default: pull_q <= 1'b0;
            endcase
        end
    end

    assign st_we   = byte_done && (st_q == ST_WDAT) && !lock;
    assign st_idx  = ptr_q[PG_AW-1:0];
    assign st_data = sh_q;
    assign go      = ev.stop && any_valid && !lock && !busy;
    assign clr     = !busy && (ev.start || (ev.stop && !go));
    assign page    = ptr_q[AW-1:PG_AW];
    assign ptr     = ptr_q;
    assign pull    = pull_q;
endmodule

// File: rtl/ser_eeprom_tgt.sv
module ser_eeprom_tgt
    import seep_pkg::*;
#(
    parameter int ARR_AW    = 11,
    parameter int PAGE_AW   = 6,
    parameter int WC_CYCLES = 400,
    parameter int SYNC_N    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_strap,
    input  logic       wr_lock,
    output logic       sda_pull_o
);
    bus_ev_t               ev;
    logic                  stg_we, stg_clr, fsm_clr, any_valid, stg_vld, wc_busy, wc_done, wc_go;
    logic [PAGE_AW-1:0]    stg_widx, stg_ridx;
    logic [7:0]            stg_wdata, stg_rdata, rd_q;
    logic [ARR_AW-PAGE_AW-1:0] wc_page;
    logic [ARR_AW-1:0]     ptr;

    seep_line_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    seep_xfer_fsm #(.AW(ARR_AW), .PG_AW(PAGE_AW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (sel_strap),
        .lock      (wr_lock),
        .busy      (wc_busy),
        .any_valid (any_valid),
        .rd_q      (rd_q),
        .pull      (sda_pull_o),
        .st_we     (stg_we),
        .st_idx    (stg_widx),
        .st_data   (stg_wdata),
        .go        (wc_go),
        .clr       (fsm_clr),
        .page      (wc_page),
        .ptr       (ptr)
    );

    assign stg_clr = fsm_clr | wc_done;

    seep_page_stage #(.PG_AW(PAGE_AW)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (stg_we),
        .wr_idx    (stg_widx),
        .wr_data   (stg_wdata),
        .clr       (stg_clr),
        .rd_idx    (stg_ridx),
        .rd_data   (stg_rdata),
        .rd_valid  (stg_vld),
        .any_valid (any_valid)
    );

    seep_store #(.AW(ARR_AW), .PG_AW(PAGE_AW), .WC_CYC(WC_CYCLES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .go      (wc_go),
        .page    (wc_page),
        .busy    (wc_busy),
        .done    (wc_done),
        .st_idx  (stg_ridx),
        .st_data (stg_rdata),
        .st_vld  (stg_vld),
        .rd_addr (ptr),
        .rd_q    (rd_q)
    );
endmodule

// File: rtl/seep_checker.sv
module seep_checker #(
    parameter int WC_CYCLES = 400
) (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic wr_lock,
    input logic sda_pull_o,
    input logic busy
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= 0;
        else              run_q <= run_q + 1;
    end

    AST_SILENT_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull_o);                                   // R9

    AST_CYCLE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < WC_CYCLES));                           // R9

    AST_LOCK_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wr_lock));                        // R10

    AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);                        // R12
endmodule

bind ser_eeprom_tgt seep_checker #(.WC_CYCLES(WC_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .wr_lock    (wr_lock),
    .sda_pull_o (sda_pull_o),
    .busy       (wc_busy)
);

// File: tb/ser_eeprom_tgt_bench.sv
module ser_eeprom_tgt_bench;
    localparam int QTR = 8;
    localparam logic [7:0] CW_B = 8'hAA;  // 1010_101_0
    localparam logic [7:0] CR_B = 8'hAB;  // 1010_101_1

    logic clk = 1'b0, rst = 1'b1;
    logic scl_h = 1'b1, sda_h = 1'b1, lock = 1'b0;
    logic sda_pull, sda_bus;
    int   n_chk = 0, n_fail = 0, viol = 0;
    bit   finished = 1'b0;

    logic [7:0] wq[$];
    logic [7:0] got_q[$];
    logic [7:0] exp_v[$];
    string      exp_tag[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_h & ~sda_pull;

    ser_eeprom_tgt u_ser_eeprom_tgt (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_h),
        .sda_i      (sda_bus),
        .sel_strap  (3'b101),
        .wr_lock    (lock),
        .sda_pull_o (sda_pull)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_b(input logic [7:0] v, input string tag);
        exp_v.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0] g, e;
        string t;
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                g = got_q.pop_front();
                if (exp_v.size() == 0) begin
                    chk("scoreboard-extra", {24'h0, g}, 32'hFFFF_FFFF);
                end else begin
                    e = exp_v.pop_front();
                    t = exp_tag.pop_front();
                    chk(t, {24'h0, g}, {24'h0, e});
                end
            end
        end
    end

    // R12 drive-timing monitor
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && sda_pull !== prev && scl_h) viol++;
            prev = sda_pull;
        end
    end

    task automatic qw();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); sda_h = 1'b0; qw(); scl_h = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qw(); scl_h = 1'b1; qw(); sda_h = 1'b1; qw();
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; qw(); scl_h = 1'b1; qw(); qw(); scl_h = 1'b0; qw();
        end
        sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); ack = ~sda_bus; qw(); scl_h = 1'b0; qw();
    endtask

    task automatic rx_byte(output logic [7:0] b, input logic more);
        b = '0;
        sda_h = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw(); scl_h = 1'b1; qw(); b = {b[6:0], sda_bus}; qw(); scl_h = 1'b0;
        end
        qw(); sda_h = more ? 1'b0 : 1'b1; qw(); scl_h = 1'b1; qw(); qw(); scl_h = 1'b0; qw();
        sda_h = 1'b1;
    endtask

    task automatic send_addr(input logic [15:0] a, input string tag);
        logic ack;
        tx_byte(CW_B, ack);   chk({tag, " ctrl ack"}, ack, 1);
        tx_byte(a[15:8], ack); chk({tag, " hi ack"}, ack, 1);
        tx_byte(a[7:0], ack);  chk({tag, " lo ack"}, ack, 1);
    endtask

    task automatic write_seq(input logic [15:0] a, input logic exp_ack, input string tag);
        logic ack;
        bus_start();
        send_addr(a, tag);
        foreach (wq[i]) begin
            tx_byte(wq[i], ack);
            chk({tag, " data ack"}, ack, exp_ack);
        end
        bus_stop();
        wq.delete();
    endtask

    task automatic rx_n(input int n);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            rx_byte(b, i < n - 1);
            got_q.push_back(b);
        end
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_addr(a, tag);
        bus_start();
        tx_byte(CR_B, ack); chk({tag, " read ctrl ack"}, ack, 1);
        rx_n(n);
        bus_stop();
    endtask

    task automatic probe(output logic ack);
        bus_start();
        tx_byte(CW_B, ack);
        bus_stop();
    endtask

    task automatic wait_ready(input string tag);
        logic ack;
        int   tries = 0;
        probe(ack);
        chk({tag, " first poll refused"}, ack, 0);
        while (!ack && tries < 40) begin
            probe(ack);
            tries++;
        end
        chk({tag, " poll eventually acked"}, ack, 1);
    endtask

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 sda released", sda_pull, 0);
        probe(ack); chk("R1 ctrl acked after reset", ack, 1);

        // R2: wrong select bits and wrong prefix
        bus_start(); tx_byte(8'hA0, ack); bus_stop(); chk("R2 wrong strap nack", ack, 0);
        bus_start(); tx_byte(8'hBA, ack); bus_stop(); chk("R2 wrong prefix nack", ack, 0);

        // R4 byte write, R9 acknowledge polling right after STOP
        wq.push_back(8'h5A); write_seq(16'h0010, 1, "R4");
        wait_ready("R9");
        wq.push_back(8'h11); write_seq(16'h0040, 1, "R4");
        wait_ready("R9");
        expect_b(8'h5A, "R6 random read 0x010");
        read_seq(16'h0010, 1, "R6");

        // R5 page write wrapping inside page 0
        for (int i = 0; i < 10; i++) wq.push_back(8'hC0 + 8'(i));
        write_seq(16'h0038, 1, "R5");
        wait_ready("R9");
        expect_b(8'hC8, "R5 wrapped byte 0x000");
        expect_b(8'hC9, "R5 wrapped byte 0x001");
        read_seq(16'h0000, 2, "R5");
        for (int i = 0; i < 8; i++) expect_b(8'hC0 + 8'(i), "R5 page tail");
        read_seq(16'h0038, 8, "R5");

        // R7 current-address read continues at 0x040
        expect_b(8'h11, "R7 current read next page unchanged");
        bus_start(); tx_byte(CR_B, ack); chk("R7 ctrl ack", ack, 1); rx_n(1); bus_stop();

        // R8 sequential across page boundary
        expect_b(8'hC7, "R8 seq 0x03F");
        expect_b(8'h11, "R8 seq 0x040");
        read_seq(16'h003F, 2, "R8");

        // R3 high address bits ignored
        expect_b(8'h5A, "R3 alias 0x0810");
        read_seq(16'h0810, 1, "R3");

        // R8 wrap from last address to 0
        wq.push_back(8'hE7); write_seq(16'h07FF, 1, "R8");
        wait_ready("R9");
        expect_b(8'hE7, "R8 last address");
        expect_b(8'hC8, "R8 wrap to 0");
        read_seq(16'h07FF, 2, "R8");

        // R10 write lock
        lock = 1'b1;
        wq.push_back(8'h33); write_seq(16'h0010, 0, "R10");
        probe(ack); chk("R10 no write cycle", ack, 1);
        lock = 1'b0;
        expect_b(8'h5A, "R10 array unchanged");
        read_seq(16'h0010, 1, "R10");

        // R11 START before STOP discards staged bytes
        bus_start(); send_addr(16'h0010, "R11");
        tx_byte(8'h77, ack); chk("R11 data ack", ack, 1);
        bus_start(); send_addr(16'h0010, "R11");
        bus_start(); tx_byte(CR_B, ack); chk("R11 read ctrl ack", ack, 1);
        expect_b(8'h5A, "R11 discarded data in-transaction");
        rx_n(1); bus_stop();
        probe(ack); chk("R11 no write cycle", ack, 1);
        expect_b(8'h5A, "R11 array unchanged");
        read_seq(16'h0010, 1, "R11");

        // R13 address only, no data
        write_seq(16'h0020, 1, "R13");
        probe(ack); chk("R13 no write cycle", ack, 1);

        repeat (20) @(negedge clk);
        chk("R12 SDA drive changed while SCL high", viol, 0);
        chk("scoreboard drained", exp_v.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule